// File: doc/BRIEF.md
# Fuzzy Membership Degree Evaluator

This block grades two 8-bit crisp inputs against a table of fuzzy membership functions that can be rewritten at run time. Each input owns its own table of up to 15 slots. Each slot holds either a triangle or a trapezoid, described by corner points on the 0..255 axis. The table is filled through a single write port: one 32-bit word of packed corner points, a shape bit, a table select and a slot index.

A start pulse latches both inputs. The block then walks the slots in index order, one slot per cycle for both tables at once. For every slot it stores a membership degree from 0 to 255, with 255 meaning full membership, and it sets a bit in a per-input bitmap when that degree is nonzero. A rule stage that follows can use the bitmaps to skip functions that did not fire, and can read the degrees of the ones that did. When the last slot has been graded, `done` rises.

Top module: `fz_mf_eval`

## Requirements
- R1: After reset, `busy` and `done` are 0, every degree is 0 and both bitmaps are 0.
- R2: A write while idle stores one slot. In the 32-bit word, corner a is bits [7:0], b is [15:8], c is [23:16] and d is [31:24]. Shape bit 1 selects a trapezoid and 0 selects a triangle. Table select 0 writes the x1 table and 1 writes the x2 table. A write while `busy` is high changes nothing.
- R3: A start while idle latches x1 and x2 and begins an evaluation. A start while `busy` is high is ignored.
- R4: `busy` stays high for exactly NMF+1 cycles after the accepted start. `done` rises in the cycle `busy` falls, is never high together with `busy`, and holds until the next accepted start clears it.
- R5: A triangle (a,b,c) gives 0 for x≤a, (x−a)·255/(b−a) for a<x<b, 255 at x=b, (c−x)·255/(c−b) for b<x<c, and 0 for x≥c. Field d is ignored.
- R6: A trapezoid (a,b,c,d) gives 0 for x≤a, (x−a)·255/(b−a) for a<x<b, 255 for b≤x≤c, (d−x)·255/(d−c) for c<x<d, and 0 for x≥d.
- R7: An edge of zero width (a==b, or the two falling corners equal) is a step: 0 at or outside the outer corner, 255 just inside it.
- R8: Full membership is encoded as 255, and slope divisions truncate toward zero. For example, 80 against trapezoid (0,30,60,90) gives 85, and 80 against (60,90,150,180) gives 170.
- R9: Bit k of each bitmap is 1 exactly when the degree of slot k for that input is nonzero.
- R10: A slot that has not been written since reset grades as 0 and is inactive.
- R11: Changes on x1 or x2 while `busy` is high do not affect the results.
- R12: Each input is graded only against its own table. The degree of slot k sits at bits [8k+7:8k] of that input's degree bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Table select: 0 for x1, 1 for x2 |
| wr_idx | input | 4 | Slot index |
| wr_trap | input | 1 | Shape: 1 for trapezoid, 0 for triangle |
| wr_word | input | 32 | Packed corners {d,c,b,a} |
| start | input | 1 | Begin an evaluation |
| x1 | input | 8 | First crisp input |
| x2 | input | 8 | Second crisp input |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | Results valid |
| deg_x1 | output | 120 | Degrees of the x1 slots, 8 bits each |
| deg_x2 | output | 120 | Degrees of the x2 slots, 8 bits each |
| act_x1 | output | 15 | Slots of x1 with a nonzero degree |
| act_x2 | output | 15 | Slots of x2 with a nonzero degree |

## Verification
Some properties are checked on every cycle: the handshake timing (the length of the busy window, `done` on exit and held after it, `busy` and `done` never together), that results stay still while idle, and that every bitmap bit agrees with its degree. The arithmetic of the shapes cannot be checked that way. Neither can the step edges, the isolation of each input from the other's table, or the fact that writes and input changes during a run have no effect. The bench shows these by comparing every degree against its own model, using both random tables and directed cases.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic          trap;
    logic [DW-1:0] d;
    logic [DW-1:0] c;
    logic [DW-1:0] b;
    logic [DW-1:0] a;
  } mf_entry_t;

  typedef enum logic {S_IDLE, S_RUN} seq_state_t;
endpackage

// File: rtl/fz_mf_store.sv
module fz_mf_store #(
  parameter int NMF  = 15,
  parameter int IDXW = $clog2(NMF)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDXW-1:0]     waddr,
  input  fz_pkg::mf_entry_t   wdata,
  input  logic [IDXW-1:0]     raddr,
  output fz_pkg::mf_entry_t   rdata,
  output logic                rvld
);
  fz_pkg::mf_entry_t mem [NMF];
  logic [NMF-1:0] vld_q;

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rvld  <= 1'b0;
    end else begin
      if (we) vld_q[waddr] <= 1'b1;
      rvld <= vld_q[raddr];
    end
  end
endmodule

// File: rtl/fz_mf_degree.sv
module fz_mf_degree #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]     x,
  input  fz_pkg::mf_entry_t ent,
  input  logic              vld,
  output logic [DW-1:0]     deg
);
  localparam int W2 = 2 * DW;
  localparam logic [DW-1:0] FULL = '1;

  logic [DW-1:0] f_lo, f_hi, rise, fall, diff_r, diff_f;
  logic [W2-1:0] q_r, q_f;

  assign f_lo = ent.trap ? ent.c : ent.b;
  assign f_hi = ent.trap ? ent.d : ent.c;

  always_comb begin
    diff_r = '0;
    q_r    = '0;
    if (x <= ent.a) rise = '0;
    else if (x >= ent.b) rise = FULL;
    else begin
      diff_r = x - ent.a;
      q_r    = (W2'(diff_r) * W2'(FULL)) / W2'(ent.b - ent.a);
      rise   = (q_r > W2'(FULL)) ? FULL : q_r[DW-1:0];
    end
  end

  always_comb begin
    diff_f = '0;
    q_f    = '0;
    if (x >= f_hi) fall = '0;
    else if (x <= f_lo) fall = FULL;
    else begin
      diff_f = f_hi - x;
      q_f    = (W2'(diff_f) * W2'(FULL)) / W2'(f_hi - f_lo);
      fall   = (q_f > W2'(FULL)) ? FULL : q_f[DW-1:0];
    end
  end

  assign deg = !vld ? '0 : ((rise < fall) ? rise : fall);
endmodule

// File: rtl/fz_mf_eval.sv
module fz_mf_eval #(
  parameter int NMF  = 15,
  parameter int DW   = 8,
  parameter int IDXW = $clog2(NMF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic              wr_trap,
  input  logic [4*DW-1:0]   wr_word,
  input  logic              start,
  input  logic [DW-1:0]     x1,
  input  logic [DW-1:0]     x2,
  output logic              busy,
  output logic              done,
  output logic [NMF*DW-1:0] deg_x1,
  output logic [NMF*DW-1:0] deg_x2,
  output logic [NMF-1:0]    act_x1,
  output logic [NMF-1:0]    act_x2
);
  import fz_pkg::*;
  localparam int CW = $clog2(NMF + 1);

  seq_state_t     state;
  logic [CW-1:0]  cnt;
  logic           p_vld;
  logic [IDXW-1:0] p_idx;
  logic [DW-1:0]  xl [2];
  logic           start_acc;
  mf_entry_t      wentry;

  logic [NMF*DW-1:0] deg_flat [2];
  logic [NMF-1:0]    act_flat [2];

  assign busy      = (state == S_RUN);
  assign start_acc = start && !busy;
  assign wentry    = {wr_trap, wr_word};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      p_vld <= 1'b0;
      p_idx <= '0;
      done  <= 1'b0;
      xl[0] <= '0;
      xl[1] <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          p_vld <= 1'b0;
          if (start) begin
            state <= S_RUN;
            cnt   <= '0;
            done  <= 1'b0;
            xl[0] <= x1;
            xl[1] <= x2;
          end
        end
        default: begin
          if (cnt < CW'(NMF)) begin
            p_vld <= 1'b1;
            p_idx <= cnt[IDXW-1:0];
            cnt   <= cnt + 1'b1;
          end else begin
            p_vld <= 1'b0;
          end
          if (p_vld && p_idx == IDXW'(NMF - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_in
    mf_entry_t     rd_ent;
    logic          rd_vld;
    logic [DW-1:0] cur_deg;
    logic [DW-1:0] deg_q [NMF];
    logic [NMF-1:0] act_q;
    logic          we_g;

    assign we_g = wr_en && !busy && (wr_sel == 1'(g)) && (int'(wr_idx) < NMF);

    fz_mf_store #(.NMF(NMF), .IDXW(IDXW)) u_store (
      .clk(clk), .rst(rst), .we(we_g), .waddr(wr_idx), .wdata(wentry),
      .raddr(cnt[IDXW-1:0]), .rdata(rd_ent), .rvld(rd_vld)
    );

    fz_mf_degree #(.DW(DW)) u_deg (
      .x(xl[g]), .ent(rd_ent), .vld(rd_vld), .deg(cur_deg)
    );

    always_ff @(posedge clk) begin
      if (rst || start_acc) begin
        for (int k = 0; k < NMF; k++) deg_q[k] <= '0;
        act_q <= '0;
      end else if (p_vld) begin
        deg_q[p_idx] <= cur_deg;
        act_q[p_idx] <= (cur_deg != '0);
      end
    end

    for (genvar k = 0; k < NMF; k++) begin : g_pack
      assign deg_flat[g][k*DW +: DW] = deg_q[k];
    end
    assign act_flat[g] = act_q;
  end

  assign deg_x1 = deg_flat[0];
  assign deg_x2 = deg_flat[1];
  assign act_x1 = act_flat[0];
  assign act_x2 = act_flat[1];
endmodule

// File: rtl/fz_mf_eval_chk.sv
module fz_mf_eval_chk #(
  parameter int NMF = 15,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [NMF*DW-1:0] deg_x1,
  input logic [NMF*DW-1:0] deg_x2,
  input logic [NMF-1:0]    act_x1,
  input logic [NMF-1:0]    act_x2
);
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else run_len <= busy ? run_len + 16'd1 : 16'd0;
  end

  function automatic logic [NMF-1:0] nz_map(input logic [NMF*DW-1:0] v);
    logic [NMF-1:0] m;
    for (int k = 0; k < NMF; k++) m[k] = (v[k*DW +: DW] != '0);
    return m;
  endfunction

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  a_r4_run_len: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len <= 16'(NMF)));
  a_r4_done_on_exit: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && run_len == 16'(NMF + 1)));
  a_r4_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  a_r3_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r9_act_map: assert property (@(posedge clk) disable iff (rst)
    (act_x1 == nz_map(deg_x1)) && (act_x2 == nz_map(deg_x2)));
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(deg_x1) && $stable(deg_x2)));
endmodule

bind fz_mf_eval fz_mf_eval_chk #(.NMF(NMF), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .deg_x1(deg_x1), .deg_x2(deg_x2), .act_x1(act_x1), .act_x2(act_x2)
);

// File: tb/sim_fz_mf_eval.sv
module sim_fz_mf_eval;
  localparam int NMF = 15;
  localparam int DW  = 8;

  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_sel = 0, wr_trap = 0, start = 0;
  logic [3:0] wr_idx = 0;
  logic [31:0] wr_word = 0;
  logic [7:0] x1 = 0, x2 = 0;
  logic busy, done;
  logic [NMF*DW-1:0] deg_x1, deg_x2;
  logic [NMF-1:0] act_x1, act_x2;

  int checks = 0, errors = 0;
  int rtyp [2][NMF];
  int rp   [2][NMF][4];
  bit rv   [2][NMF];

  fz_mf_eval u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_trap(wr_trap), .wr_word(wr_word), .start(start), .x1(x1), .x2(x2),
    .busy(busy), .done(done), .deg_x1(deg_x1), .deg_x2(deg_x2),
    .act_x1(act_x1), .act_x2(act_x2)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ramp_up(int x, int lo, int hi);
    if (x <= lo) return 0;
    if (x >= hi) return 255;
    return ((x - lo) * 255) / (hi - lo);
  endfunction

  function automatic int ramp_dn(int x, int lo, int hi);
    if (x >= hi) return 0;
    if (x <= lo) return 255;
    return ((hi - x) * 255) / (hi - lo);
  endfunction

  function automatic int model(int s, int k, int x);
    int u, v;
    if (!rv[s][k]) return 0;
    u = ramp_up(x, rp[s][k][0], rp[s][k][1]);
    if (rtyp[s][k] == 1) v = ramp_dn(x, rp[s][k][2], rp[s][k][3]);
    else v = ramp_dn(x, rp[s][k][1], rp[s][k][2]);
    return (u < v) ? u : v;
  endfunction

  function automatic int got_deg(int s, int k);
    return s ? int'(deg_x2[k*DW +: DW]) : int'(deg_x1[k*DW +: DW]);
  endfunction

  task automatic wr(input int s, input int k, input bit trap,
                    input int a, input int b, input int c, input int d);
    @(negedge clk);
    wr_en = 1; wr_sel = 1'(s); wr_idx = 4'(k); wr_trap = trap;
    wr_word = {8'(d), 8'(c), 8'(b), 8'(a)};
    @(negedge clk);
    wr_en = 0;
    rv[s][k] = 1; rtyp[s][k] = trap;
    rp[s][k][0] = a; rp[s][k][1] = b; rp[s][k][2] = c; rp[s][k][3] = d;
  endtask

  task automatic run(input int vx1, input int vx2, input bit inject);
    int n = 0;
    x1 = 8'(vx1); x2 = 8'(vx2);
    @(negedge clk);
    start = 1;
    do begin
      @(negedge clk);
      n++;
      start = 0;
      if (n == 1) chk(busy === 1'b1, "R3 busy after start", busy, 1);
      if (inject && n == 3) begin x1 = 8'(vx1 ^ 8'h5a); x2 = 8'(vx2 ^ 8'ha5); end
      if (inject && n == 5) begin
        wr_en = 1; wr_sel = 0; wr_idx = 0; wr_trap = 1; wr_word = 32'h0;
        start = 1;
      end
      if (inject && n == 6) begin wr_en = 0; start = 0; end
    end while (!done && n < 200);
    chk(n == NMF + 2, "R4 done latency", n, NMF + 2);
    chk(busy === 1'b0, "R4 busy low at done", busy, 0);
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < NMF; k++) begin
        int e, g;
        string tag;
        e = model(s, k, s ? vx2 : vx1);
        g = got_deg(s, k);
        tag = !rv[s][k] ? "R10 unwritten slot" :
              (rtyp[s][k] == 1 ? "R6 trapezoid degree" : "R5 triangle degree");
        chk(g == e, tag, g, e);
        chk((s ? act_x2[k] : act_x1[k]) == (e != 0), "R9 active bit",
            int'(s ? act_x2[k] : act_x1[k]), int'(e != 0));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < NMF; k++) begin
        rv[s][k] = 0; rtyp[s][k] = 0;
        for (int j = 0; j < 4; j++) rp[s][k][j] = 0;
      end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy === 0 && done === 0, "R1 reset handshake", int'({busy, done}), 0);
    chk(deg_x1 == '0 && deg_x2 == '0, "R1 reset degrees", int'(deg_x1[7:0]), 0);
    chk(act_x1 == '0 && act_x2 == '0, "R1 reset bitmaps", int'(act_x1), 0);

    // directed: packing, per-input tables, worked values
    wr(0, 0, 1, 0, 30, 60, 90);
    wr(1, 0, 1, 0, 30, 60, 90);
    wr(1, 1, 1, 60, 90, 150, 180);
    wr(1, 2, 0, 150, 180, 230, 7);
    run(40, 80, 1);
    chk(got_deg(0, 0) == 255, "R8 full membership x1", got_deg(0, 0), 255);
    chk(got_deg(1, 0) == 85, "R8 falling slope x2 slot0", got_deg(1, 0), 85);
    chk(got_deg(1, 1) == 170, "R8 rising slope x2 slot1", got_deg(1, 1), 170);
    chk(got_deg(1, 2) == 0, "R12 triangle outside x2 slot2", got_deg(1, 2), 0);
    chk(act_x1 == 15'h0001, "R12 x1 sees only its own table", int'(act_x1), 1);
    chk(got_deg(0, 0) == 255, "R2 write during busy ignored", got_deg(0, 0), 255);
    chk(got_deg(0, 0) == 255, "R11 input change during busy ignored", got_deg(0, 0), 255);

    // zero-width edges
    wr(0, 2, 1, 50, 50, 100, 100);
    run(50, 0, 0);
    chk(got_deg(0, 2) == 0, "R7 step at lower corner", got_deg(0, 2), 0);
    run(51, 0, 0);
    chk(got_deg(0, 2) == 255, "R7 step just inside", got_deg(0, 2), 255);
    run(99, 0, 0);
    chk(got_deg(0, 2) == 255, "R7 falling step inside", got_deg(0, 2), 255);
    run(100, 0, 0);
    chk(got_deg(0, 2) == 0, "R7 falling step at corner", got_deg(0, 2), 0);

    // random tables and inputs
    for (int r = 0; r < 25; r++) begin
      for (int w = 0; w < 6; w++) begin
        int v[4];
        int s, k;
        bit t;
        for (int j = 0; j < 4; j++) v[j] = $urandom_range(0, 255);
        for (int i = 0; i < 3; i++)
          for (int j = 0; j < 3 - i; j++)
            if (v[j] > v[j+1]) begin int tmp = v[j]; v[j] = v[j+1]; v[j+1] = tmp; end
        s = $urandom_range(0, 1);
        k = $urandom_range(0, NMF - 1);
        t = 1'($urandom_range(0, 1));
        if (t) wr(s, k, 1, v[0], v[1], v[2], v[3]);
        else   wr(s, k, 0, v[0], v[1], v[3], $urandom_range(0, 255));
      end
      run($urandom_range(0, 255), $urandom_range(0, 255), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule